// File: doc/BRIEF.md
# TDM Receive Frame Sync Unit

This block handles frame synchronisation for the receive side of a serial audio port and runs entirely on the receive bit clock. It either produces the frame sync itself and drives it onto a pin, or it watches a sync that arrives from outside and locks onto it. In both cases it gives the rest of the receiver a one-cycle frame-start strobe and a running slot index, so that the data path knows where each slot begins without counting bits itself.

A nine-bit mode input picks the frame shape. The frame can be a single-slot burst that fires on request, a TDM frame of 2 to 32 slots (two slots is the usual stereo case), or a long 384-slot frame. Three more control inputs choose the sync source, the edge that marks a frame start, and whether a generated pulse lasts one bit or one whole slot. Slot length is a parameter. The control inputs are held in an active copy, and that copy is replaced only at a frame boundary. A change made mid-frame therefore never truncates a running frame or its sync pulse.

Top module: `fsync_rx_unit`

## Requirements
- R1: After reset, fs_pin_o, fs_oe_o and frame_start_o are 0 and slot_idx_o is 0. With all control inputs at 0 the block acts as an external-sync burst receiver that starts on a rising edge.
- R2: Mode code 0 selects burst (one slot per frame), codes 2 to 32 select a TDM frame of that many slots, and code 384 selects a 384-slot frame. A generated TDM frame repeats every slot count times SLOT_BITS bit clocks.
- R3: Mode codes 1, 33 to 383 and 385 to 511 are invalid. With an invalid code no frame_start_o pulse occurs, fs_oe_o is 0 and slot_idx_o stays 0, whether sync is internal or external.
- R4: fs_oe_o is 1 exactly when internal generation (cfg_internal_i = 1) is active with a valid mode. When fs_oe_o is 0, fs_pin_o is 0.
- R5: With cfg_fall_i = 0 a frame starts on a rising sync edge, and a generated sync is high while active and low otherwise. With cfg_fall_i = 1 a falling edge starts a frame, and the generated levels are inverted.
- R6: With cfg_slotwide_i = 0 the generated sync is active for 1 bit clock per frame. With cfg_slotwide_i = 1 it is active for SLOT_BITS bit clocks.
- R7: In external mode, a sync edge of the selected direction sampled at a clock edge raises frame_start_o for one cycle after that edge with slot_idx_o = 0. An edge of the other direction has no effect.
- R8: In internal burst mode, one frame (one sync pulse, one frame_start_o) is generated for each start_req_i seen while idle, and none is generated without a request.
- R9: slot_idx_o is 0 while frame_start_o is 1. It advances by one every SLOT_BITS bit clocks and returns to 0 after the last slot of the frame.
- R10: Control inputs changed during a frame take effect only at the end of that frame. The running frame keeps its old length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receive bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_mode_i | input | 9 | Frame mode code |
| cfg_internal_i | input | 1 | 1: generate sync, 0: detect external sync |
| cfg_fall_i | input | 1 | 1: falling edge starts a frame, 0: rising edge |
| cfg_slotwide_i | input | 1 | 1: generated pulse lasts one slot, 0: one bit |
| start_req_i | input | 1 | Request one frame in internal burst mode |
| fs_pin_i | input | 1 | Sync level sampled from the pin |
| fs_pin_o | output | 1 | Generated sync level for the pin |
| fs_oe_o | output | 1 | Pin output enable |
| frame_start_o | output | 1 | One-cycle strobe at the first bit of a frame |
| slot_idx_o | output | 9 | Index of the current slot |

## Verification
Generated TDM frames are run with random slot counts, polarities and widths. For each frame the bench measures the period, the number of active sync cycles and the highest slot index, so a wrong slot count, an inverted level or a wrong pulse length shows up as its own mismatch. External sync is driven with both edge directions under both polarity settings, which separates real edge detection from level sensing. Reserved codes, a mid-frame mode change, burst start requests and the 384-slot frame cover the decode boundaries and the rule that changes wait for the frame boundary.

// File: rtl/fsync_rx_pkg.sv
package fsync_rx_pkg;

    localparam int unsigned MODE_W   = 9;
    localparam int unsigned TDM_MIN  = 2;
    localparam int unsigned TDM_MAX  = 32;
    localparam int unsigned LONG_SLT = 384;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic              internal;
        logic              fall;
        logic              wide;
    } fs_cfg_t;

    function automatic logic mode_ok(input logic [MODE_W-1:0] m);
        return (m == '0) ||
               ((m >= MODE_W'(TDM_MIN)) && (m <= MODE_W'(TDM_MAX))) ||
               (m == MODE_W'(LONG_SLT));
    endfunction

    function automatic logic mode_burst(input logic [MODE_W-1:0] m);
        return (m == '0);
    endfunction

endpackage

// File: rtl/fsync_mode_dec.sv
module fsync_mode_dec
    import fsync_rx_pkg::*;
(
    input  logic [MODE_W-1:0] mode_i,
    output logic              valid_o,
    output logic [MODE_W-1:0] last_slot_o
);
    always_comb begin
        valid_o     = mode_ok(mode_i);
        last_slot_o = '0;
        if (valid_o && !mode_burst(mode_i)) begin
            last_slot_o = mode_i - MODE_W'(1);
        end
    end
endmodule

// File: rtl/fsync_edge_det.sv
module fsync_edge_det (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pin_i,
    input  logic fall_i,
    output logic edge_o
);
    logic prev_d, prev_q;

    always_comb begin
        prev_d = pin_i;
        if (fall_i) begin
            edge_o = prev_q && !pin_i;
        end else begin
            edge_o = !prev_q && pin_i;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
        end else begin
            prev_q <= prev_d;
        end
    end
endmodule

// File: rtl/fsync_pin_drv.sv
module fsync_pin_drv (
    input  logic run_i,
    input  logic slot_zero_i,
    input  logic bit_zero_i,
    input  logic wide_i,
    input  logic fall_i,
    input  logic gen_en_i,
    output logic pin_o,
    output logic oe_o
);
    logic active;

    always_comb begin
        active = run_i && slot_zero_i && (wide_i || bit_zero_i);
        oe_o   = gen_en_i;
        pin_o  = gen_en_i ? (active ^ fall_i) : 1'b0;
    end
endmodule

// File: rtl/fsync_rx_unit.sv
module fsync_rx_unit
    import fsync_rx_pkg::*;
#(
    parameter int unsigned SLOT_BITS = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [MODE_W-1:0] cfg_mode_i,
    input  logic              cfg_internal_i,
    input  logic              cfg_fall_i,
    input  logic              cfg_slotwide_i,
    input  logic              start_req_i,
    input  logic              fs_pin_i,
    output logic              fs_pin_o,
    output logic              fs_oe_o,
    output logic              frame_start_o,
    output logic [MODE_W-1:0] slot_idx_o
);
    localparam int unsigned BIT_W    = (SLOT_BITS > 2) ? $clog2(SLOT_BITS) : 1;
    localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(SLOT_BITS - 1);

    typedef struct packed {
        fs_cfg_t           act;
        logic              run;
        logic [BIT_W-1:0]  bit_cnt;
        logic [MODE_W-1:0] slot;
        logic              start;
    } fs_state_t;

    fs_state_t st_d, st_q;

    fs_cfg_t           cfg_in;
    fs_cfg_t           cfg_eff;
    logic              act_valid;
    logic [MODE_W-1:0] act_last;
    logic              last_bit;
    logic              frame_end;
    logic              boundary;
    logic              eff_valid;
    logic              ext_edge;
    logic              begin_frame;

    fsync_mode_dec u_act_dec (
        .mode_i      (st_q.act.mode),
        .valid_o     (act_valid),
        .last_slot_o (act_last)
    );

    fsync_edge_det u_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .pin_i  (fs_pin_i),
        .fall_i (cfg_eff.fall),
        .edge_o (ext_edge)
    );

    fsync_pin_drv u_drv (
        .run_i       (st_q.run),
        .slot_zero_i (st_q.slot == '0),
        .bit_zero_i  (st_q.bit_cnt == '0),
        .wide_i      (st_q.act.wide),
        .fall_i      (st_q.act.fall),
        .gen_en_i    (st_q.act.internal && act_valid),
        .pin_o       (fs_pin_o),
        .oe_o        (fs_oe_o)
    );

    always_comb begin
        cfg_in.mode     = cfg_mode_i;
        cfg_in.internal = cfg_internal_i;
        cfg_in.fall     = cfg_fall_i;
        cfg_in.wide     = cfg_slotwide_i;

        last_bit  = (st_q.bit_cnt == LAST_BIT);
        frame_end = st_q.run && last_bit && (st_q.slot == act_last);
        boundary  = !st_q.run || frame_end;
        cfg_eff   = boundary ? cfg_in : st_q.act;
        eff_valid = mode_ok(cfg_eff.mode);

        st_d       = st_q;
        st_d.start = 1'b0;
        if (boundary) begin
            st_d.act = cfg_in;
        end

        if (st_q.run) begin
            if (frame_end) begin
                st_d.run     = 1'b0;
                st_d.bit_cnt = '0;
                st_d.slot    = '0;
            end else if (last_bit) begin
                st_d.bit_cnt = '0;
                st_d.slot    = st_q.slot + MODE_W'(1);
            end else begin
                st_d.bit_cnt = st_q.bit_cnt + BIT_W'(1);
            end
        end

        begin_frame = 1'b0;
        if (eff_valid) begin
            if (cfg_eff.internal) begin
                if (mode_burst(cfg_eff.mode)) begin
                    begin_frame = boundary && start_req_i;
                end else begin
                    begin_frame = boundary;
                end
            end else begin
                begin_frame = ext_edge;
            end
        end

        if (begin_frame) begin
            st_d.run     = 1'b1;
            st_d.bit_cnt = '0;
            st_d.slot    = '0;
            st_d.start   = 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign frame_start_o = st_q.start;
    assign slot_idx_o    = st_q.slot;

endmodule

// File: rtl/fsync_rx_chk.sv
module fsync_rx_chk
    import fsync_rx_pkg::*;
(
    input logic              clk_i,
    input logic              rst_ni,
    input logic              fs_pin_o,
    input logic              fs_oe_o,
    input logic              frame_start_o,
    input logic [MODE_W-1:0] slot_idx_o
);
    AST_START_AT_SLOT0: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |-> (slot_idx_o == '0)); // R9

    AST_SLOT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (slot_idx_o != $past(slot_idx_o)) |->
        ((slot_idx_o == $past(slot_idx_o) + MODE_W'(1)) || (slot_idx_o == '0))); // R9

    AST_PIN_QUIET_NO_OE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !fs_oe_o |-> !fs_pin_o); // R4

    AST_START_ISOLATED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        frame_start_o |=> !frame_start_o); // R7

    AST_SLOT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        slot_idx_o < MODE_W'(LONG_SLT)); // R2

    always_comb begin
        if (!rst_ni) begin
            AST_RESET_IDLE: assert (!frame_start_o && !fs_oe_o && (slot_idx_o == '0)); // R1
        end
    end
endmodule

bind fsync_rx_unit fsync_rx_chk u_chk (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .fs_pin_o      (fs_pin_o),
    .fs_oe_o       (fs_oe_o),
    .frame_start_o (frame_start_o),
    .slot_idx_o    (slot_idx_o)
);

// File: tb/fsync_rx_unit_tb_top.sv
`timescale 1ns/1ps
module fsync_rx_unit_tb_top;
    localparam int SB = 8;

    logic       clk_i = 1'b0;
    logic       rst_ni = 1'b0;
    logic [8:0] cfg_mode_i = '0;
    logic       cfg_internal_i = 1'b0;
    logic       cfg_fall_i = 1'b0;
    logic       cfg_slotwide_i = 1'b0;
    logic       start_req_i = 1'b0;
    logic       fs_pin_i = 1'b0;
    logic       fs_pin_o;
    logic       fs_oe_o;
    logic       frame_start_o;
    logic [8:0] slot_idx_o;

    int tests = 0;
    int fails = 0;

    always #4 clk_i = ~clk_i;

    fsync_rx_unit #(.SLOT_BITS(SB)) dut_i (
        .clk_i          (clk_i),
        .rst_ni         (rst_ni),
        .cfg_mode_i     (cfg_mode_i),
        .cfg_internal_i (cfg_internal_i),
        .cfg_fall_i     (cfg_fall_i),
        .cfg_slotwide_i (cfg_slotwide_i),
        .start_req_i    (start_req_i),
        .fs_pin_i       (fs_pin_i),
        .fs_pin_o       (fs_pin_o),
        .fs_oe_o        (fs_oe_o),
        .frame_start_o  (frame_start_o),
        .slot_idx_o     (slot_idx_o)
    );

    function automatic int exp_period(input int n);
        return ((n == 0) ? 1 : n) * SB;
    endfunction

    function automatic int exp_width(input bit w);
        return w ? SB : 1;
    endfunction

    function automatic int exp_last(input int n);
        return (n == 0) ? 0 : n - 1;
    endfunction

    task automatic check(input string req, input string what, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic set_cfg(input int m, input bit intl, input bit f, input bit w);
        cfg_mode_i     = 9'(m);
        cfg_internal_i = intl;
        cfg_fall_i     = f;
        cfg_slotwide_i = w;
    endtask

    task automatic wait_start(output bit ok);
        ok = 1'b0;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk_i);
            if (frame_start_o) begin
                ok = 1'b1;
                break;
            end
        end
    endtask

    task automatic measure(input bit f, output int period, output int width, output int maxslot);
        period  = 0;
        width   = (fs_pin_o == !f) ? 1 : 0;
        maxslot = slot_idx_o;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk_i);
            period++;
            if (frame_start_o) break;
            if (fs_pin_o == !f) width++;
            if (slot_idx_o > maxslot) maxslot = slot_idx_o;
        end
    endtask

    task automatic run_tdm(input string req, input int n, input bit f, input bit w);
        bit ok;
        int p, wd, ms;
        set_cfg(n, 1'b1, f, w);
        wait_start(ok);
        check(req, "frame start seen", int'(ok), 1);
        check("R9", "slot at frame start", int'(slot_idx_o), 0);
        check("R4", "oe in internal", int'(fs_oe_o), 1);
        measure(f, p, wd, ms);
        check("R2", $sformatf("period n=%0d", n), p, exp_period(n));
        check("R6", $sformatf("active width w=%0d f=%0d", w, f), wd, exp_width(w));
        check("R9", "highest slot", ms, exp_last(n));
    endtask

    task automatic count_starts(input int cycles, output int cnt, output int slot_nz);
        cnt = 0;
        slot_nz = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk_i);
            if (frame_start_o) cnt++;
            if (slot_idx_o != 0) slot_nz++;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        tests++;
        fails++;
        $display("FAIL R2 watchdog expired: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        bit ok;
        int p, wd, ms, cnt, nz;
        void'($urandom(32'd4242));

        repeat (4) @(negedge clk_i);
        check("R1", "pin in reset", int'(fs_pin_o), 0);
        check("R1", "oe in reset", int'(fs_oe_o), 0);
        check("R1", "start in reset", int'(frame_start_o), 0);
        check("R1", "slot in reset", int'(slot_idx_o), 0);
        rst_ni = 1'b1;
        repeat (3) @(negedge clk_i);
        check("R1", "oe after reset", int'(fs_oe_o), 0);
        fs_pin_i = 1'b1;
        @(negedge clk_i);
        check("R1", "default rising edge starts frame", int'(frame_start_o), 1);
        fs_pin_i = 1'b0;
        repeat (SB + 3) @(negedge clk_i);

        // directed I2S case and the extremes of the TDM range
        run_tdm("R2", 2, 1'b0, 1'b0);
        run_tdm("R2", 32, 1'b1, 1'b1);
        for (int k = 0; k < 6; k++) begin
            int n;
            n = 2 + int'($urandom % 31);
            run_tdm("R5", n, bit'($urandom % 2), bit'($urandom % 2));
        end

        // R10: mid-frame change waits for the frame end
        set_cfg(4, 1'b1, 1'b0, 1'b0);
        wait_start(ok);
        wait_start(ok);
        repeat (5) @(negedge clk_i);
        set_cfg(2, 1'b1, 1'b0, 1'b0);
        p = 5;
        for (int i = 0; i < 5000; i++) begin
            @(negedge clk_i);
            p++;
            if (frame_start_o) break;
        end
        check("R10", "old frame length kept", p, exp_period(4));
        measure(1'b0, p, wd, ms);
        check("R10", "new frame length after boundary", p, exp_period(2));

        // R3: reserved codes, internal
        for (int k = 0; k < 5; k++) begin
            int m;
            case (k)
                0: m = 1;
                1: m = 33;
                2: m = 383;
                3: m = 385;
                default: m = 33 + int'($urandom % 351);
            endcase
            set_cfg(m, 1'b1, 1'b0, 1'b0);
            repeat (40) @(negedge clk_i);
            count_starts(100, cnt, nz);
            check("R3", $sformatf("starts with code %0d", m), cnt, 0);
            check("R3", "oe with reserved code", int'(fs_oe_o), 0);
            check("R3", "slot stays 0", nz, 0);
        end
        // R3: reserved code, external edges ignored
        set_cfg(511, 1'b0, 1'b0, 1'b0);
        fs_pin_i = 1'b1;
        count_starts(5, cnt, nz);
        fs_pin_i = 1'b0;
        count_starts(5, cnt, nz);
        check("R3", "external edge with reserved code", cnt, 0);

        // R8: internal burst, falling polarity, slot-wide
        set_cfg(0, 1'b1, 1'b1, 1'b1);
        count_starts(50, cnt, nz);
        check("R8", "no frame without request", cnt, 0);
        check("R5", "idle level with falling polarity", int'(fs_pin_o), 1);
        start_req_i = 1'b1;
        @(negedge clk_i);
        start_req_i = 1'b0;
        check("R8", "start after request", int'(frame_start_o), 1);
        check("R5", "active level with falling polarity", int'(fs_pin_o), 0);
        wd = 1;
        cnt = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk_i);
            if (frame_start_o) cnt++;
            if (!fs_pin_o) wd++;
        end
        check("R8", "no repeat of burst", cnt, 0);
        check("R6", "burst pulse length", wd, SB);

        // R7: external 4-slot frame, rising then falling polarity
        set_cfg(4, 1'b0, 1'b0, 1'b0);
        repeat (3) @(negedge clk_i);
        check("R4", "oe in external mode", int'(fs_oe_o), 0);
        fs_pin_i = 1'b1;
        @(negedge clk_i);
        check("R7", "start after rising edge", int'(frame_start_o), 1);
        check("R7", "slot at external start", int'(slot_idx_o), 0);
        repeat (SB) @(negedge clk_i);
        check("R9", "slot after one slot time", int'(slot_idx_o), 1);
        fs_pin_i = 1'b0;
        @(negedge clk_i);
        check("R7", "falling edge ignored", int'(frame_start_o), 0);
        repeat (4 * SB) @(negedge clk_i);
        set_cfg(4, 1'b0, 1'b1, 1'b0);
        repeat (2) @(negedge clk_i);
        fs_pin_i = 1'b1;
        @(negedge clk_i);
        check("R5", "rising edge ignored with falling polarity", int'(frame_start_o), 0);
        fs_pin_i = 1'b0;
        @(negedge clk_i);
        check("R5", "falling edge starts frame", int'(frame_start_o), 1);
        repeat (4 * SB + 2) @(negedge clk_i);

        // R2: long 384-slot frame
        run_tdm("R2", 384, 1'b0, 1'b0);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule